// File: doc/BRIEF.md
# Shared Receive Character Silo for a Sixteen-Line Serial Multiplexer

This block gathers characters that the per-line deserializers have already assembled and queues them in one first-in first-out silo shared by all lines. Each line presents a one-cycle strobe with its byte and its parity and framing error indications. A per-line holding register catches the byte. A lowest-line-first arbiter then moves one held byte per cycle into the silo, tagged with the line number and its error bits.

Software reads a single character register to take the oldest entry. The top bit of that word says whether a character was present, so a driver can drain the silo by reading until the word is non-negative. A control/status register carries the enables and flags for two interrupts. The receive interrupt fires when the silo stops being empty. The storage interrupt fires when the fill level climbs to a programmable alarm level. The same register also holds a maintenance bit that isolates the line inputs, and a master-clear command.

Register selects: 0 is the control/status register, 1 is the receive character register, 2 is the alarm-level register, and 3 is unused.

Top module: `rx_silo`

## Requirements
- R1: After reset the silo and all holding registers are empty. The control/status register reads 0, the alarm-level register reads the ALARM_RESET parameter, the character register reads 0, and both interrupt outputs are low.
- R2: The character register (select 1) reads a word with bit 15 set when the silo holds an entry, and reads all zeros when the silo is empty. A cycle with rdEn high on select 1 removes the oldest entry. A read of an empty silo leaves all state unchanged.
- R3: In a character word, bits 7:0 are the character and bits 11:8 are the receiving line number. Bit 12 is the parity error, bit 13 is the framing error, and bit 14 is the overrun flag.
- R4: At most one entry is written per cycle. Entries leave in the order they were written. Among lines holding a character, the lowest line number is written first.
- R5: A character strobed on a line is captured at the next clock edge. When no lower-numbered line is holding a character, it is written to the silo at the following edge and becomes readable after that edge.
- R6: If a line strobes a new character while its previous one is still held and not being written that cycle, the new character replaces the old one. The next entry written to the silo then has bit 14 set.
- R7: If a held character is chosen while the silo holds DEPTH entries, the character is dropped and the silo is left unchanged. The next entry written then has bit 14 set. After any write, bit 14 clears for later entries unless another loss occurs.
- R8: Control bit 7, the receive flag, sets whenever the entry count goes from zero to non-zero. Control bit 6 is the receive enable. irqRx is high whenever enable and flag are both set, including right after the enable is written while the flag is already set.
- R9: Control bit 14, the storage flag, sets when the entry count rises from below the alarm level to reach it. Control bit 12 is the storage enable, and irqStore is high when both are set. The alarm-level register (select 2) is written from the low bits of wrData. An alarm level of 0 never sets the flag.
- R10: A control write without bit 11 loads bits 6, 9 and 12. It clears each flag written as 0 and keeps each flag written as 1. A flag event in the same cycle wins. Writes to selects 1 and 3 are ignored, and select 3 reads zero.
- R11: While control bit 9 (maintenance) is set, line strobes are ignored. Characters already held still enter the silo.
- R12: A control write with bit 11 set empties the silo, discards held characters and clears the pending overrun. It clears all control bits, ignores the other bits of that write, and leaves the alarm level unchanged. Bit 11 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineValid | input | NUM_LINES | Per-line one-cycle character strobe |
| lineData | input | 8*NUM_LINES | Per-line character, line n in bits 8n+7:8n |
| lineParErr | input | NUM_LINES | Per-line parity error with the strobe |
| lineFrmErr | input | NUM_LINES | Per-line framing error (break) with the strobe |
| regSel | input | 2 | Register select for reads and writes |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops on select 1) |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for the current select |
| irqRx | output | 1 | Receive interrupt request |
| irqStore | output | 1 | Storage (alarm-level) interrupt request |

## Verification
The bench builds the block with sixteen lines, a silo only 8 entries deep and an alarm level of 4. With these values, full-silo drops and alarm crossings occur within a few cycles of traffic. The priority arbiter still spans the whole line-number field. A behavioural model with a queue and per-line holding arrays is compared against the read data and both interrupts on every clock. Hand-computed words cover the collision and overflow cases, and a long random phase mixes arrivals on many lines with pops, flag writes and master clears.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  typedef enum logic [1:0] {
    SEL_CSR    = 2'd0,
    SEL_RXCHAR = 2'd1,
    SEL_ALARM  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // control/status bit positions (decoded by software)
  localparam int CSR_RX_IE   = 6;
  localparam int CSR_RX_FLAG = 7;
  localparam int CSR_MAINT   = 9;
  localparam int CSR_MCLR    = 11;
  localparam int CSR_ST_IE   = 12;
  localparam int CSR_ST_FLAG = 14;

  // silo entry width: overrun, framing, parity, 4-bit line, 8-bit char
  localparam int ENTRY_W = 15;

  typedef struct packed {
    logic popReq;
    logic clearAll;
    logic blockLines;
  } siloCtl_t;

endpackage

// File: rtl/rx_silo_dp.sv
module rx_silo_dp
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  siloCtl_t               ctl,
  input  logic [NUM_LINES-1:0]   lineValid,
  input  logic [8*NUM_LINES-1:0] lineData,
  input  logic [NUM_LINES-1:0]   lineParErr,
  input  logic [NUM_LINES-1:0]   lineFrmErr,
  output logic [CNT_W-1:0]       count,
  output logic [CNT_W-1:0]       countNext,
  output logic [15:0]            rxWord
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0]        holdValid, holdPar, holdFrm;
  logic [NUM_LINES-1:0][7:0]   holdData;
  logic [NUM_LINES-1:0]        capture, collision, grantVec;
  logic [IDX_W-1:0]            grantIdx;
  logic                        grantAny;
  logic                        full, empty, pushEn, popEn, dropFull;
  logic                        ovrPending;
  logic [AW-1:0]               wrPtr, rdPtr;
  logic [ENTRY_W-1:0]          mem [DEPTH];
  logic [ENTRY_W-1:0]          newEntry;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] ptr);
    return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  endfunction

  assign capture   = lineValid & {NUM_LINES{~ctl.blockLines}};
  assign collision = capture & holdValid & ~grantVec;

  // fixed priority: lowest line number wins
  always_comb begin
    grantIdx = '0;
    grantVec = '0;
    grantAny = |holdValid;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (holdValid[i]) grantIdx = IDX_W'(i);
    end
    if (grantAny) grantVec[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= '0;
      holdPar   <= '0;
      holdFrm   <= '0;
      holdData  <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (ctl.clearAll) begin
          holdValid[i] <= 1'b0;
        end else if (capture[i]) begin
          holdValid[i] <= 1'b1;
          holdData[i]  <= lineData[8*i +: 8];
          holdPar[i]   <= lineParErr[i];
          holdFrm[i]   <= lineFrmErr[i];
        end else if (grantVec[i]) begin
          holdValid[i] <= 1'b0;
        end
      end
    end
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign pushEn   = grantAny & ~full & ~ctl.clearAll;
  assign dropFull = grantAny & full;
  assign popEn    = ctl.popReq & ~empty & ~ctl.clearAll;
  assign newEntry = {ovrPending, holdFrm[grantIdx], holdPar[grantIdx],
                     4'(grantIdx), holdData[grantIdx]};

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= newEntry;
  end

  always_comb begin
    if (ctl.clearAll) countNext = '0;
    else countNext = count + CNT_W'(pushEn) - CNT_W'(popEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      ovrPending <= 1'b0;
    end else begin
      count <= countNext;
      if (ctl.clearAll) begin
        wrPtr      <= '0;
        rdPtr      <= '0;
        ovrPending <= 1'b0;
      end else begin
        if (pushEn) wrPtr <= advance(wrPtr);
        if (popEn)  rdPtr <= advance(rdPtr);
        if ((|collision) || dropFull) ovrPending <= 1'b1;
        else if (pushEn)              ovrPending <= 1'b0;
      end
    end
  end

  assign rxWord = empty ? 16'h0000 : {1'b1, mem[rdPtr]};

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clearAll && full && grantAny && !ctl.popReq) |=> (full && ovrPending)); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn) |=> (count == $past(count) - CNT_W'(1))); // R2
  AST_MAINT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.blockLines && !ctl.clearAll && holdValid == '0) |=> (holdValid == '0)); // R11

endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
  import rx_silo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_RESET = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [15:0]      wrData,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] countNext,
  input  logic [15:0]      rxWord,
  output siloCtl_t         ctl,
  output logic [15:0]      rdData,
  output logic             irqRx,
  output logic             irqStore
);

  localparam logic [CNT_W-1:0] ALARM_INIT = CNT_W'(ALARM_RESET);

  regSel_e          sel;
  logic             rxIe, rxFlag, stIe, stFlag, maint;
  logic [CNT_W-1:0] alarm;
  logic             mcStrobe, csrWr, alarmWr, rxEvent, stEvent;
  logic [15:0]      csrWord;

  assign sel      = regSel_e'(regSel);
  assign mcStrobe = wrEn && (sel == SEL_CSR) && wrData[CSR_MCLR];
  assign csrWr    = wrEn && (sel == SEL_CSR) && !wrData[CSR_MCLR];
  assign alarmWr  = wrEn && (sel == SEL_ALARM);
  assign rxEvent  = !mcStrobe && (count == '0) && (countNext != '0);
  assign stEvent  = !mcStrobe && (alarm != '0) && (count < alarm) && (countNext >= alarm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIe   <= 1'b0;
      rxFlag <= 1'b0;
      stIe   <= 1'b0;
      stFlag <= 1'b0;
      maint  <= 1'b0;
    end else if (mcStrobe) begin
      rxIe   <= 1'b0;
      rxFlag <= 1'b0;
      stIe   <= 1'b0;
      stFlag <= 1'b0;
      maint  <= 1'b0;
    end else if (csrWr) begin
      rxIe   <= wrData[CSR_RX_IE];
      stIe   <= wrData[CSR_ST_IE];
      maint  <= wrData[CSR_MAINT];
      rxFlag <= rxEvent || (rxFlag && wrData[CSR_RX_FLAG]);
      stFlag <= stEvent || (stFlag && wrData[CSR_ST_FLAG]);
    end else begin
      rxFlag <= rxFlag || rxEvent;
      stFlag <= stFlag || stEvent;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        alarm <= ALARM_INIT;
    else if (alarmWr) alarm <= wrData[CNT_W-1:0];
  end

  assign ctl.popReq     = rdEn && (sel == SEL_RXCHAR);
  assign ctl.clearAll   = mcStrobe;
  assign ctl.blockLines = maint;

  always_comb begin
    csrWord              = '0;
    csrWord[CSR_RX_IE]   = rxIe;
    csrWord[CSR_RX_FLAG] = rxFlag;
    csrWord[CSR_MAINT]   = maint;
    csrWord[CSR_ST_IE]   = stIe;
    csrWord[CSR_ST_FLAG] = stFlag;
    unique case (sel)
      SEL_CSR:    rdData = csrWord;
      SEL_RXCHAR: rdData = rxWord;
      SEL_ALARM:  rdData = 16'(alarm);
      default:    rdData = 16'h0000;
    endcase
  end

  assign irqRx    = rxIe && rxFlag;
  assign irqStore = stIe && stFlag;

  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxEvent |=> rxFlag); // R8
  AST_ST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    stEvent |=> stFlag); // R9
  AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    mcStrobe |=> (!rxIe && !rxFlag && !stIe && !stFlag && !maint)); // R12
  AST_ALARM_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !alarmWr |=> $stable(alarm)); // R9

endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int DEPTH       = 64,
  parameter int ALARM_RESET = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   lineValid,
  input  logic [8*NUM_LINES-1:0] lineData,
  input  logic [NUM_LINES-1:0]   lineParErr,
  input  logic [NUM_LINES-1:0]   lineFrmErr,
  input  logic [1:0]             regSel,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [15:0]            wrData,
  output logic [15:0]            rdData,
  output logic                   irqRx,
  output logic                   irqStore
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  siloCtl_t         ctl;
  logic [CNT_W-1:0] count, countNext;
  logic [15:0]      rxWord;

  rx_silo_ctrl #(.DEPTH(DEPTH), .ALARM_RESET(ALARM_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .count(count), .countNext(countNext), .rxWord(rxWord),
    .ctl(ctl), .rdData(rdData), .irqRx(irqRx), .irqStore(irqStore)
  );

  rx_silo_dp #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lineValid(lineValid),
    .lineData(lineData), .lineParErr(lineParErr), .lineFrmErr(lineFrmErr),
    .count(count), .countNext(countNext), .rxWord(rxWord)
  );

endmodule

// File: tb/rx_silo_tb.sv
module rx_silo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int D  = 8;
  localparam int AR = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NL-1:0]   lv = '0;
  logic [8*NL-1:0] ld = '0;
  logic [NL-1:0]   lp = '0;
  logic [NL-1:0]   lf = '0;
  logic [1:0]      sel = 2'd0;
  logic            wr = 1'b0;
  logic            rd = 1'b0;
  logic [15:0]     wd = '0;
  logic [15:0]     rdData;
  logic            irqRx, irqStore;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rx_silo #(.NUM_LINES(NL), .DEPTH(D), .ALARM_RESET(AR)) u_dut (
    .clk(clk), .rstN(rstN), .lineValid(lv), .lineData(ld), .lineParErr(lp),
    .lineFrmErr(lf), .regSel(sel), .wrEn(wr), .rdEn(rd), .wrData(wd),
    .rdData(rdData), .irqRx(irqRx), .irqStore(irqStore)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  logic [14:0] silo[$];
  bit          pend [NL];
  logic [7:0]  pDat [NL];
  bit          pPar [NL];
  bit          pFrm [NL];
  bit          mOvr, mRxIe, mRxFl, mStIe, mStFl, mMaint;
  logic [3:0]  mAlarm;

  task automatic modelReset();
    silo.delete();
    for (int i = 0; i < NL; i++) pend[i] = 0;
    mOvr = 0; mRxIe = 0; mRxFl = 0; mStIe = 0; mStFl = 0; mMaint = 0;
  endtask

  task automatic modelStep();
    int  cntOld, cntNew, g;
    bit  rxEv, stEv;
    if (wr && sel == 2'd0 && wd[11]) begin
      modelReset();
      return;
    end
    cntOld = silo.size();
    if (rd && sel == 2'd1 && cntOld > 0) void'(silo.pop_front());
    g = -1;
    for (int i = NL - 1; i >= 0; i--) if (pend[i]) g = i;
    if (g >= 0) begin
      if (cntOld < D) begin
        silo.push_back({mOvr, pFrm[g], pPar[g], 4'(g), pDat[g]});
        mOvr = 0;
      end else mOvr = 1;
      pend[g] = 0;
    end
    for (int i = 0; i < NL; i++) begin
      if (lv[i] && !mMaint) begin
        if (pend[i]) mOvr = 1;
        pend[i] = 1; pDat[i] = ld[8*i +: 8]; pPar[i] = lp[i]; pFrm[i] = lf[i];
      end
    end
    cntNew = silo.size();
    rxEv = (cntOld == 0) && (cntNew != 0);
    stEv = (mAlarm != 0) && (cntOld < int'(mAlarm)) && (cntNew >= int'(mAlarm));
    if (wr && sel == 2'd0) begin
      mRxIe = wd[6]; mStIe = wd[12]; mMaint = wd[9];
      mRxFl = rxEv | (mRxFl & wd[7]);
      mStFl = stEv | (mStFl & wd[14]);
    end else begin
      mRxFl = mRxFl | rxEv;
      mStFl = mStFl | stEv;
    end
    if (wr && sel == 2'd2) mAlarm = wd[3:0];
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
      mAlarm = 4'(AR);
    end else modelStep();
  end

  function automatic logic [15:0] modelRead(input logic [1:0] s);
    logic [15:0] w = '0;
    case (s)
      2'd0: begin
        w[6] = mRxIe; w[7] = mRxFl; w[9] = mMaint; w[12] = mStIe; w[14] = mStFl;
      end
      2'd1: w = (silo.size() == 0) ? 16'h0 : {1'b1, silo[0]};
      2'd2: w = 16'(mAlarm);
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    string t;
    if (!rstN) return;
    case (sel)
      2'd1:    t = "R2 char read";
      2'd2:    t = "R9 alarm read";
      default: t = "R10 control read";
    endcase
    check(t, rdData, modelRead(sel));
    check("R8 irqRx", 16'(irqRx), 16'(mRxIe && mRxFl));
    check("R9 irqStore", 16'(irqStore), 16'(mStIe && mStFl));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    lv = '0; rd = 0; wr = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic putChar(input int line, input logic [7:0] c, input bit par, input bit frm);
    lv[line] = 1'b1; ld[8*line +: 8] = c; lp[line] = par; lf[line] = frm;
  endtask

  task automatic clearLines();
    lv = '0; lp = '0; lf = '0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [15:0] w);
    sel = s; rd = 0; wr = 0;
    #1 w = rdData;
  endtask

  task automatic popChar(output logic [15:0] w);
    sel = 2'd1; rd = 1; wr = 0;
    #1 w = rdData;
    step();
    rd = 0;
  endtask

  task automatic writeReg(input logic [1:0] s, input logic [15:0] v);
    sel = s; wr = 1; rd = 0; wd = v;
    step();
    wr = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 reset values
    peek(2'd0, w); check("R1 control after reset", w, 16'h0000);
    peek(2'd2, w); check("R1 alarm after reset", w, 16'(AR));
    peek(2'd1, w); check("R1 char after reset", w, 16'h0000);
    check("R1 irqRx after reset", 16'(irqRx), 16'h0);
    check("R1 irqStore after reset", 16'(irqStore), 16'h0);

    // R5 latency and R3 field layout
    putChar(5, 8'hA5, 1, 0); step(); clearLines();
    peek(2'd1, w); check("R5 not yet in silo", w, 16'h0000);
    step();
    peek(2'd1, w); check("R5 readable after second edge", w, 16'h95A5);
    popChar(w); check("R3 fields line5 parity", w, 16'h95A5);
    peek(2'd1, w); check("R2 empty after pop", w, 16'h0000);
    check("R8 irq masked while disabled", 16'(irqRx), 16'h0);
    writeReg(2'd0, 16'h00C0);
    #1 check("R8 enable with flag set raises irq", 16'(irqRx), 16'h1);
    writeReg(2'd0, 16'h0040);
    peek(2'd0, w); check("R10 flag cleared by zero", w, 16'h0040);

    // R3 framing bit
    putChar(12, 8'h00, 0, 1); step(); clearLines(); idle(2);
    popChar(w); check("R3 framing line12", w, 16'hAC00);

    // R4 priority among simultaneous arrivals
    putChar(3, 8'h31, 0, 0); putChar(1, 8'h11, 0, 0); putChar(9, 8'h91, 0, 0);
    step(); clearLines(); idle(4);
    popChar(w); check("R4 first lowest line", w, 16'h8111);
    popChar(w); check("R4 second", w, 16'h8331);
    popChar(w); check("R4 third", w, 16'h8991);
    popChar(w); check("R2 empty read", w, 16'h0000);

    // R6 collision on a held line
    putChar(0, 8'h00, 0, 0); putChar(2, 8'h22, 0, 0); step(); clearLines();
    putChar(2, 8'h23, 0, 0); step(); clearLines(); idle(3);
    popChar(w); check("R6 entry before collision", w, 16'h8000);
    popChar(w); check("R6 replaced char with overrun", w, 16'hC223);

    // R7 full silo drop, with storage interrupt enabled
    writeReg(2'd0, 16'h1040);
    for (int k = 0; k < D + 1; k++) begin
      putChar(7, 8'(k), 0, 0); step();
    end
    clearLines(); idle(3);
    check("R9 storage irq at alarm", 16'(irqStore), 16'h1);
    popChar(w); check("R7 oldest kept", w, 16'h8700);
    putChar(7, 8'h0A, 0, 0); step(); clearLines(); idle(2);
    for (int k = 1; k < D; k++) begin
      popChar(w); check("R7 stored entries", w, 16'h8700 | 16'(k));
    end
    popChar(w); check("R7 overrun after drop", w, 16'hC70A);
    popChar(w); check("R7 then empty", w, 16'h0000);

    // R11 maintenance isolates lines
    writeReg(2'd0, 16'h0200);
    putChar(1, 8'h55, 0, 0); step(); clearLines(); idle(3);
    peek(2'd1, w); check("R11 strobe ignored", w, 16'h0000);
    writeReg(2'd0, 16'h0000);

    // R12 master clear
    writeReg(2'd2, 16'h0002);
    writeReg(2'd0, 16'h1240);
    putChar(3, 8'h33, 0, 0); putChar(4, 8'h44, 0, 0); putChar(6, 8'h66, 0, 0);
    step(); clearLines();
    step();
    writeReg(2'd0, 16'h1840);
    idle(3);
    peek(2'd0, w); check("R12 control cleared", w, 16'h0000);
    peek(2'd1, w); check("R12 silo and holds emptied", w, 16'h0000);
    peek(2'd2, w); check("R12 alarm kept", w, 16'h0002);

    // random mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      lv = 16'($urandom & $urandom & $urandom);
      ld = {$urandom, $urandom, $urandom, $urandom};
      lp = 16'($urandom); lf = 16'($urandom & $urandom);
      wr = 0; rd = ($urandom % 3) == 0;
      sel = (($urandom % 4) == 0) ? 2'($urandom) : 2'd1;
      if (($urandom % 25) == 0) begin
        wr = 1;
        if ($urandom % 2) begin
          sel = 2'd0;
          wd = 16'($urandom) & 16'h52C0;
          if (($urandom % 6) == 0) wd[11] = 1'b1;
        end else begin
          sel = 2'd2; wd = 16'($urandom % 9);
        end
      end
      step();
    end
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule